// File: doc/BRIEF.md
# DRAM power-up initializer and refresh scheduler

This block sits beside the access sequencer of an EDO DRAM controller. After reset it keeps every row and column strobe inactive for a parameterised power-up pause of 200 µs by default. It then asks for the memory and runs a burst of CAS-before-RAS cycles so that the DRAM's internal row counter is primed. Only after that does it flag the array as ready. From then on a free-running interval timer raises a refresh request a little faster than once every 15.6 µs. This keeps 2048 rows within a 32 ms window. The DRAM's own counter supplies the row address, so no address is driven.

Ownership of the strobes is negotiated through a request/grant pair. The block raises `rfsh_req`. It starts a refresh cycle only in the clock after it sees the grant. It then drives all RAS lines and all CAS lines of both banks together until the cycle ends. `busy` tells the external multiplexer when these strobes must be routed to the array. One refresh may wait while the sequencer holds the memory. If a further one comes due while two are still outstanding, a sticky `overrun` flag is set.

Top module: `dram_rfsh_init`

## Requirements
- R1: During reset and for PAUSE_NS/CLK_NS clock cycles after reset is released, all RAS and CAS lines stay high and `rfsh_req` stays low. `rfsh_req` rises in exactly that cycle (20000 cycles with the defaults).
- R2: `init_done` stays low until eight refresh cycles have completed after the pause. It goes high in the clock after the eighth cycle's precharge ends, and stays high until reset.
- R3: Each refresh cycle orders its strobes as follows. At least one clock with all strobes high (≥5 ns) comes after the start. CAS then falls while RAS is still high, at least 10 ns before RAS falls. CAS stays low for the whole time RAS is low.
- R4: `we_n` is held high at all times, so it is high before and after every RAS falling edge.
- R5: RAS stays low for at least 60 ns (6 clocks by default). RAS is high for at least 40 ns between low phases. One low phase plus the high time before the next one is at least 104 ns.
- R6: All RAS lines switch together, and all CAS lines switch together, so both banks are refreshed by one cycle.
- R7: Once `init_done` is high, a refresh request is raised every REF_INTERVAL_NS/CLK_NS cycles (1500 by default). This interval never exceeds the 15.625 µs average that 2048 rows in 32 ms allow.
- R8: A refresh cycle starts only in the clock after `rfsh_req` and `rfsh_gnt` are both high, and `busy` is high for its whole 13-clock length. A cycle in progress runs to its end even if `rfsh_gnt` falls.
- R9: Up to two refreshes may be outstanding without loss. A timer request that arrives while two are outstanding sets `overrun`, which then stays high until reset.
- R10: `rfsh_req` stays high while any initialization or refresh cycle is outstanding or running. It falls in the clock after the last one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_gnt | input | 1 | Grant from the access sequencer; the block may start a cycle while it is high |
| rfsh_req | output | 1 | Request for ownership of the strobes |
| ras_n | output | RAS_LINES | Row strobes, active low, all lines identical |
| cas_n | output | CAS_LINES | Column strobes, active low, all lines identical |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up pause and priming cycles are complete |
| busy | output | 1 | A refresh cycle is driving the strobes |
| overrun | output | 1 | Sticky: a refresh request was lost |

## Verification
On every clock, the assertions check the quiet pause, strobe ordering, minimum RAS low and precharge widths, lockstep bank lines, WE high, the gap between timer requests, and that starts happen only on a grant. They also check that `overrun` is sticky. Only the bench's scenarios can show that exactly eight priming cycles precede `init_done`, and that refresh falls are spaced by exactly the interval. The bench scenarios also show that a withheld grant queues two refreshes without loss, that a third one lost sets `overrun`, and that a dropped grant does not cut a cycle short.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  // DRAM timing minima in nanoseconds
  localparam int T_CBR_PRECH_NS = 5;    // CAS high before it falls for refresh
  localparam int T_CAS_SETUP_NS = 10;   // CAS low before RAS falls
  localparam int T_CAS_HOLD_NS  = 10;   // CAS low after RAS falls
  localparam int T_RAS_LOW_NS   = 60;
  localparam int T_RAS_HIGH_NS  = 40;
  localparam int T_CYCLE_NS     = 104;
  localparam int T_AVG_LIMIT_NS = 15625; // 32 ms / 2048 rows

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GAP,
    SQ_CAS,
    SQ_RAS,
    SQ_PRE
  } sq_state_t;

  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int gap_cycles(input int clk_ns);
    return imax(1, cyc_ceil(T_CBR_PRECH_NS, clk_ns));
  endfunction

  function automatic int csu_cycles(input int clk_ns);
    return imax(1, cyc_ceil(T_CAS_SETUP_NS, clk_ns));
  endfunction

  function automatic int ras_cycles(input int clk_ns);
    return imax(cyc_ceil(T_RAS_LOW_NS, clk_ns), cyc_ceil(T_CAS_HOLD_NS, clk_ns));
  endfunction

  function automatic int pre_cycles(input int clk_ns);
    return imax(cyc_ceil(T_RAS_HIGH_NS, clk_ns),
                cyc_ceil(T_CYCLE_NS, clk_ns) - ras_cycles(clk_ns));
  endfunction

endpackage

// File: rtl/rfsh_pause_init.sv
module rfsh_pause_init #(
  parameter int PAUSE_CYC   = 20000,
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_done,
  output logic pause_done,
  output logic init_open,
  output logic init_done
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] init_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_cnt  <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      pause_cnt <= pause_cnt + 1'b1;
      if (pause_cnt == PW'(PAUSE_CYC - 1)) pause_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      init_left <= IW'(INIT_CYCLES);
    else if (cycle_done && init_left != '0)
      init_left <= init_left - 1'b1;
  end

  assign init_open = pause_done && (init_left != '0);
  assign init_done = (init_left == '0);
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int IVL_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cycle_done,
  output logic tick,
  output logic owed,
  output logic overrun
);
  localparam int TW = $clog2(IVL_CYC);

  logic [TW-1:0] cnt;
  logic [1:0]    pend;
  logic          retire;

  assign tick   = run && (cnt == TW'(IVL_CYC - 1));
  assign retire = cycle_done && (pend != 2'd0);
  assign owed   = (pend != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (run)
      cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 2'd0;
      overrun <= 1'b0;
    end else begin
      unique case ({tick, retire})
        2'b10: begin
          if (pend == 2'd2) overrun <= 1'b1;
          else              pend    <= pend + 2'd1;
        end
        2'b01:   pend <= pend - 2'd1;
        default: pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import dram_rfsh_pkg::*;
#(
  parameter int T_GAP = 1,
  parameter int T_CSU = 1,
  parameter int T_RAS = 6,
  parameter int T_PRE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_act,
  output logic cas_act,
  output logic busy,
  output logic done
);
  localparam int TMAX = imax(imax(T_GAP, T_CSU), imax(T_RAS, T_PRE));
  localparam int CW   = $clog2(TMAX + 1);

  sq_state_t     st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin st <= SQ_GAP; cnt <= CW'(T_GAP - 1); end
        SQ_GAP:  if (last) begin st <= SQ_CAS; cnt <= CW'(T_CSU - 1); end
                 else cnt <= cnt - 1'b1;
        SQ_CAS:  if (last) begin st <= SQ_RAS; cnt <= CW'(T_RAS - 1); end
                 else cnt <= cnt - 1'b1;
        SQ_RAS:  if (last) begin st <= SQ_PRE; cnt <= CW'(T_PRE - 1); end
                 else cnt <= cnt - 1'b1;
        SQ_PRE:  if (last) st <= SQ_IDLE;
                 else cnt <= cnt - 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (st != SQ_IDLE);
  assign cas_act = (st == SQ_CAS) || (st == SQ_RAS);
  assign ras_act = (st == SQ_RAS);
  assign done    = (st == SQ_PRE) && last;
endmodule

// File: rtl/dram_rfsh_init.sv
module dram_rfsh_init
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS          = 10,
  parameter int PAUSE_NS        = 200000,
  parameter int INIT_CYCLES     = 8,
  parameter int REF_INTERVAL_NS = 15000,
  parameter int RAS_LINES       = 4,
  parameter int CAS_LINES       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rfsh_gnt,
  output logic                 rfsh_req,
  output logic [RAS_LINES-1:0] ras_n,
  output logic [CAS_LINES-1:0] cas_n,
  output logic                 we_n,
  output logic                 init_done,
  output logic                 busy,
  output logic                 overrun
);
  localparam int PAUSE_CYC = cyc_ceil(PAUSE_NS, CLK_NS);
  localparam int IVL_CYC   = REF_INTERVAL_NS / CLK_NS;
  localparam int T_GAP     = gap_cycles(CLK_NS);
  localparam int T_CSU     = csu_cycles(CLK_NS);
  localparam int T_RAS     = ras_cycles(CLK_NS);
  localparam int T_PRE     = pre_cycles(CLK_NS);

  // named internal events, visible to the bound checker
  logic pause_done_w;
  logic init_open_w;
  logic tick_w;
  logic owed_w;
  logic seq_done_w;
  logic start_w;
  logic ras_act_w;
  logic cas_act_w;

  rfsh_pause_init #(
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_CYCLES(INIT_CYCLES)
  ) u_pause (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_done(seq_done_w),
    .pause_done(pause_done_w),
    .init_open (init_open_w),
    .init_done (init_done)
  );

  rfsh_interval_timer #(
    .IVL_CYC(IVL_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (init_done),
    .cycle_done(seq_done_w),
    .tick      (tick_w),
    .owed      (owed_w),
    .overrun   (overrun)
  );

  rfsh_cbr_seq #(
    .T_GAP(T_GAP),
    .T_CSU(T_CSU),
    .T_RAS(T_RAS),
    .T_PRE(T_PRE)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_w),
    .ras_act(ras_act_w),
    .cas_act(cas_act_w),
    .busy   (busy),
    .done   (seq_done_w)
  );

  assign rfsh_req = pause_done_w && (init_open_w || owed_w || busy);
  assign start_w  = rfsh_req && rfsh_gnt && !busy;

  generate
    for (genvar i = 0; i < RAS_LINES; i++) begin : g_ras
      assign ras_n[i] = ~ras_act_w;
    end
    for (genvar j = 0; j < CAS_LINES; j++) begin : g_cas
      assign cas_n[j] = ~cas_act_w;
    end
  endgenerate

  assign we_n = 1'b1;
endmodule

// File: rtl/dram_rfsh_chk.sv
module dram_rfsh_chk
  import dram_rfsh_pkg::*;
#(
  parameter int RAS_LINES = 4,
  parameter int CAS_LINES = 4,
  parameter int CLK_NS    = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rfsh_gnt,
  input logic                 rfsh_req,
  input logic [RAS_LINES-1:0] ras_n,
  input logic [CAS_LINES-1:0] cas_n,
  input logic                 we_n,
  input logic                 init_done,
  input logic                 busy,
  input logic                 overrun,
  input logic                 pause_done,
  input logic                 tick
);
  localparam int LOW_MIN  = cyc_ceil(T_RAS_LOW_NS, CLK_NS);
  localparam int HIGH_MIN = cyc_ceil(T_RAS_HIGH_NS, CLK_NS);
  localparam int RC_MIN   = cyc_ceil(T_CYCLE_NS, CLK_NS);
  localparam int GAP_MAX  = T_AVG_LIMIT_NS / CLK_NS;

  int low_run, high_run, last_low, tick_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= 0;
      high_run <= 0;
      last_low <= 0;
      tick_gap <= 0;
    end else begin
      low_run  <= ras_n[0] ? 0 : low_run + 1;
      high_run <= ras_n[0] ? high_run + 1 : 0;
      if (ras_n[0] && low_run != 0) last_low <= low_run;
      tick_gap <= (!init_done || tick) ? 0 : tick_gap + 1;
    end
  end

  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (&ras_n && &cas_n && !rfsh_req));

  p_init_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> !$past(cas_n[0]));

  p_cas_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n[0] |-> !cas_n[0]);

  p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n[0]) |-> ras_n[0]);

  p_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_n);

  p_ras_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (low_run >= LOW_MIN));

  p_ras_prech_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (high_run >= HIGH_MIN && high_run + last_low >= RC_MIN));

  p_banks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1));

  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (tick_gap + 1 <= GAP_MAX));

  p_start_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rfsh_gnt && rfsh_req));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(tick));

  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rfsh_req);
endmodule

bind dram_rfsh_init dram_rfsh_chk #(
  .RAS_LINES(RAS_LINES),
  .CAS_LINES(CAS_LINES),
  .CLK_NS   (CLK_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rfsh_gnt  (rfsh_gnt),
  .rfsh_req  (rfsh_req),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .init_done (init_done),
  .busy      (busy),
  .overrun   (overrun),
  .pause_done(pause_done_w),
  .tick      (tick_w)
);

// File: tb/tb_dram_rfsh_init.sv
`timescale 1ns/1ps
module tb_dram_rfsh_init;
  // timing restated from the requirements, 10 ns clock
  localparam int PAUSE  = 20000;
  localparam int NINIT  = 8;
  localparam int IVL    = 1500;
  localparam int GAPC   = 1;
  localparam int CSUC   = 1;
  localparam int LOWC   = 6;
  localparam int PREC   = 5;
  localparam int LEN    = GAPC + CSUC + LOWC + PREC;
  localparam int LIMIT  = 1562;   // 15.625 us in 10 ns clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gnt = 1'b0;
  logic       req, we_n, idone, busy, ovr;
  logic [3:0] ras_n, cas_n;

  always #5 clk = ~clk;

  dram_rfsh_init dut (
    .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .init_done(idone), .busy(busy), .overrun(ovr)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_since, m_left, m_tmr, m_pend, m_pos;
  bit m_ovr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_since = 0; m_left = NINIT; m_tmr = 0; m_pend = 0; m_pos = -1; m_ovr = 0;
    end else begin
      automatic bit paused = (m_since >= PAUSE);
      automatic bit ready  = (m_left == 0);
      automatic bit want   = paused && (m_left > 0 || m_pend > 0 || m_pos >= 0);
      automatic bit fin    = (m_pos == LEN - 1);
      automatic bit tk     = ready && (m_tmr == IVL - 1);
      automatic int np;
      if (fin) m_pos = -1;
      else if (m_pos >= 0) m_pos++;
      else if (want && gnt) m_pos = 0;
      if (fin && m_left > 0) m_left--;
      np = m_pend + (tk ? 1 : 0) - ((fin && m_pend > 0) ? 1 : 0);
      if (np > 2) begin np = 2; m_ovr = 1; end
      m_pend = np;
      if (ready) m_tmr = (m_tmr + 1) % IVL;
      if (m_since < PAUSE) m_since++;
    end
  end

  function automatic bit exp_req();
    return (m_since >= PAUSE) && (m_left > 0 || m_pend > 0 || m_pos >= 0);
  endfunction
  function automatic bit exp_cas_low();
    return m_pos >= GAPC && m_pos < GAPC + CSUC + LOWC;
  endfunction
  function automatic bit exp_ras_low();
    return m_pos >= GAPC + CSUC && m_pos < GAPC + CSUC + LOWC;
  endfunction

  // per-cycle comparison and strobe monitor
  int  cyc = 0;
  int  falls = 0, last_fall = -1, spacing = -1;
  int  low_w = 0, high_w = 0, min_low = 1 << 30, min_high = 1 << 30;
  bit  prev_ras = 1'b1, prev_cas = 1'b1, lead_bad = 1'b0, hold_bad = 1'b0;
  bit  monitor_on = 1'b0;

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    automatic logic [3:0] er = exp_ras_low() ? 4'h0 : 4'hF;
    automatic logic [3:0] ec = exp_cas_low() ? 4'h0 : 4'hF;
    check(ras_n === er, "R6 ras lines vs model", ras_n, er);
    check(cas_n === ec, "R3 cas lines vs model", cas_n, ec);
    check(we_n === 1'b1, "R4 we_n", we_n, 1);
    check(req === exp_req(), "R10 rfsh_req vs model", req, exp_req());
    check(busy === (m_pos >= 0), "R8 busy vs model", busy, m_pos >= 0);
    check(idone === (m_left == 0), "R2 init_done vs model", idone, m_left == 0);
    check(ovr === m_ovr, "R9 overrun vs model", ovr, m_ovr);
    if (monitor_on) begin
      if (prev_ras && !ras_n[0]) begin
        falls++;
        if (prev_cas) lead_bad = 1'b1;
        if (last_fall >= 0) spacing = cyc - last_fall;
        last_fall = cyc;
        if (high_w < min_high) min_high = high_w;
        low_w = 0;
      end
      if (!prev_ras && ras_n[0]) begin
        if (low_w < min_low) min_low = low_w;
        high_w = 0;
      end
      if (!ras_n[0]) begin low_w++; if (cas_n[0]) hold_bad = 1'b1; end
      else high_w++;
    end
    prev_ras = ras_n[0];
    prev_cas = cas_n[0];
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stim
    int f0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(ras_n === 4'hF && cas_n === 4'hF, "R1 strobes high in reset", ras_n, 4'hF);
    check(req === 1'b0, "R1 no request in reset", req, 0);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    high_w = 0;
    while (cyc < PAUSE - 1) @(negedge clk);
    check(req === 1'b0, "R1 request still low at end of pause", req, 0);
    check(ras_n === 4'hF && cas_n === 4'hF, "R1 strobes high during pause", cas_n, 4'hF);
    @(negedge clk);
    check(req === 1'b1, "R1 request rises after pause", req, 1);
    // R8: withheld grant, nothing starts
    repeat (40) @(negedge clk);
    check(busy === 1'b0 && ras_n === 4'hF, "R8 no cycle without grant", busy, 0);
    gnt = 1'b1;
    // R2: priming cycles
    while (!idone) @(negedge clk);
    check(falls == NINIT, "R2 priming cycles before init_done", falls, NINIT);
    // R7: steady spacing
    repeat (4 * IVL + 40) @(negedge clk);
    check(spacing == IVL, "R7 refresh spacing", spacing, IVL);
    check(spacing <= LIMIT, "R7 spacing within limit", spacing, LIMIT);
    // R8: drop grant right after a cycle starts
    while (!busy) @(negedge clk);
    gnt = 1'b0;
    f0 = falls;
    repeat (LEN + 2) @(negedge clk);
    check(falls == f0 + 1 && busy === 1'b0, "R8 cycle completes without grant", falls, f0 + 1);
    // R9: two outstanding, no overrun
    repeat (2 * IVL + 20) @(negedge clk);
    check(req === 1'b1 && ovr === 1'b0, "R9 two requests queued, no overrun", ovr, 0);
    f0 = falls;
    gnt = 1'b1;
    repeat (2 * LEN + 10) @(negedge clk);
    check(falls == f0 + 2, "R9 queued refreshes served back to back", falls, f0 + 2);
    check(req === 1'b0, "R10 request drops when nothing outstanding", req, 0);
    // R9: lost request
    gnt = 1'b0;
    repeat (3 * IVL + 20) @(negedge clk);
    check(ovr === 1'b1, "R9 overrun on third outstanding request", ovr, 1);
    gnt = 1'b1;
    repeat (2 * IVL) @(negedge clk);
    check(ovr === 1'b1, "R9 overrun sticky", ovr, 1);
    // R3/R5 aggregate strobe timing
    check(!lead_bad, "R3 CAS low before RAS falls", lead_bad, 0);
    check(!hold_bad, "R3 CAS low while RAS low", hold_bad, 0);
    check(min_low >= LOWC, "R5 RAS low width", min_low, LOWC);
    check(min_high >= PREC && min_high + min_low >= 11, "R5 RAS high width", min_high, PREC);
    finish_run();
  end
endmodule